// File: doc/BRIEF.md
# Embedded Video Timing Code Decoder

This block sits on a digital 4:2:2 component video stream and pulls apart the two kinds of words it carries. Timing references mark the start and end of each line's active region. Each one is three fixed preamble words followed by a status word. The block finds these references and checks the protection bits of the status word. It then keeps the field, vertical-blanking and line-edge flags the word carries. Every other word inside an active line is a video sample. Samples arrive as blue-difference chroma, luma, red-difference chroma, luma. The block turns each such group into two complete pixels that share one chroma pair.

The word width is set by the parameter `WORD_W`, which is 8 or 10. In 10-bit mode only the upper eight bits of the status word carry information. Samples enter on a valid/ready interface and pixels leave on a valid/ready interface. Both run in the same clock domain. The flags and the one-cycle pulses are plain outputs that need no handshake.

Back-pressure rules:
- A word is taken only on a rising edge where `in_valid` and `in_ready` are both high.
- `in_ready` is low while a pixel is waiting and `pix_ready` is low.
- A pixel that has been offered holds its value until `pix_ready` is seen high.

Top module: `video_trs_decoder`

## Requirements
- R1: A synchronous active-high reset clears all of the following: `pix_valid`, the pixel data, the flags `fld_f`, `vblank` and `hflag`, and every pulse output.
- R2: The fourth word of the sequence all-ones, zero, zero is a status word. Its top eight bits are 1, F, V, H, P3, P2, P1, P0, from the most significant bit down. When the status word is valid, F, V and H are loaded into `fld_f`, `vblank` and `hflag`. They are visible one cycle after the accepting edge. In 10-bit mode the two lowest bits are not decoded.
- R3: A status word is in error if its most significant bit is 0 or if its check bits differ from P3 = V^H, P2 = F^H, P1 = F^V, P0 = F^V^H. An errored status word raises `code_err` for one cycle. It leaves the flags unchanged and raises no other pulse.
- R4: A valid status word with H=0 (start of active line) raises `sav_pulse` for one cycle. A valid status word with H=1 (end of active line) raises `eav_pulse` for one cycle.
- R5: `field_start` pulses together with `sav_pulse` for the status bytes 8'h80 and 8'hC7. In 10-bit mode these are 10'h200 and 10'h31C. F=0 denotes field 1 and F=1 denotes field 2.
- R6: After a valid start-of-line status word with V=0, samples are taken in the order Cb, Y0, Cr, Y1. The pixel (Y0, Cb, Cr) is output when Cr is accepted. The pixel (Y1, Cb, Cr) is output when Y1 is accepted.
- R7: A start-of-line status word with V=1 produces no pixels until the next start-of-line word with V=0.
- R8: An end-of-line status word stops pixel output. Preamble words are never taken as samples.
- R9: While `pix_valid` is high and `pix_ready` is low, the pixel stays valid and its data is stable. During that time `in_ready` is low.
- R10: A pixel is valid on the cycle right after the edge that accepted its Cr or Y1 word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take a word |
| in_data | input | WORD_W | Video or timing word |
| pix_valid | output | 1 | Pixel offered |
| pix_ready | input | 1 | Consumer takes the pixel |
| pix_y | output | WORD_W | Pixel luma |
| pix_cb | output | WORD_W | Pixel blue-difference chroma |
| pix_cr | output | WORD_W | Pixel red-difference chroma |
| fld_f | output | 1 | Field flag of the last valid status word |
| vblank | output | 1 | Vertical-blanking flag of the last valid status word |
| hflag | output | 1 | Line-edge flag of the last valid status word |
| sav_pulse | output | 1 | One-cycle pulse: valid start-of-line code |
| eav_pulse | output | 1 | One-cycle pulse: valid end-of-line code |
| field_start | output | 1 | One-cycle pulse: field-start code |
| code_err | output | 1 | One-cycle pulse: protection failure |

## Verification
Every result appears one cycle after the edge that accepted the word causing it. Flags and pulses follow the edge that took the status word. Pixels follow the edge that took the Cr or second luma word. Directed checks run 1 ns after that accepting edge, when pulses still hold their one-cycle value. Pixel contents and hold behaviour under random back-pressure are compared at the falling edge against a queue of expected pixels built by the bench.

// File: rtl/video_trs_pkg.sv
package video_trs_pkg;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } xy_t;

  typedef enum logic [1:0] {
    PH_CB = 2'd0,
    PH_Y0 = 2'd1,
    PH_CR = 2'd2,
    PH_Y1 = 2'd3
  } phase_e;

  function automatic logic [3:0] prot_bits(input xy_t s);
    return {s.v ^ s.h, s.f ^ s.h, s.f ^ s.v, s.f ^ s.v ^ s.h};
  endfunction

endpackage

// File: rtl/trs_detect.sv
module trs_detect
  import video_trs_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic [WORD_W-1:0] word,
  output logic              is_status,
  output logic              stat_ok,
  output logic              is_sample,
  output xy_t               xy,
  output logic [7:0]        code8
);
  localparam logic [WORD_W-1:0] ONES  = '1;
  localparam logic [WORD_W-1:0] ZEROS = '0;

  logic [1:0] cnt;
  logic       pre_word;

  always_comb begin
    code8     = word[WORD_W-1 -: 8];
    xy        = '{f: code8[6], v: code8[5], h: code8[4]};
    is_status = (cnt == 2'd3);
    stat_ok   = is_status && code8[7] && (code8[3:0] == prot_bits(xy));
    pre_word  = (word == ONES) ||
                (((cnt == 2'd1) || (cnt == 2'd2)) && (word == ZEROS));
    is_sample = !is_status && !pre_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= 2'd0;
    end else if (acc) begin
      if (cnt == 2'd3)
        cnt <= 2'd0;
      else if (word == ONES)
        cnt <= 2'd1;
      else if (((cnt == 2'd1) || (cnt == 2'd2)) && (word == ZEROS))
        cnt <= cnt + 2'd1;
      else
        cnt <= 2'd0;
    end
  end
endmodule

// File: rtl/chroma_demux.sv
module chroma_demux
  import video_trs_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              start_line,
  input  logic              stop_line,
  input  logic [WORD_W-1:0] word,
  output logic              emit,
  output logic [WORD_W-1:0] emit_y,
  output logic [WORD_W-1:0] emit_cb,
  output logic [WORD_W-1:0] emit_cr
);
  logic              active;
  phase_e            phase;
  logic [WORD_W-1:0] cb_q, cr_q, y0_q;

  always_comb begin
    emit    = take && active && ((phase == PH_CR) || (phase == PH_Y1));
    emit_y  = (phase == PH_CR) ? y0_q : word;
    emit_cr = (phase == PH_CR) ? word : cr_q;
    emit_cb = cb_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      phase  <= PH_CB;
      cb_q   <= '0;
      cr_q   <= '0;
      y0_q   <= '0;
    end else if (start_line) begin
      active <= 1'b1;
      phase  <= PH_CB;
    end else if (stop_line) begin
      active <= 1'b0;
      phase  <= PH_CB;
    end else if (take && active) begin
      case (phase)
        PH_CB:   cb_q <= word;
        PH_Y0:   y0_q <= word;
        PH_CR:   cr_q <= word;
        default: ;
      endcase
      phase <= phase_e'(phase + 2'd1);
    end
  end
endmodule

// File: rtl/video_trs_decoder.sv
module video_trs_decoder
  import video_trs_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic [WORD_W-1:0] pix_y,
  output logic [WORD_W-1:0] pix_cb,
  output logic [WORD_W-1:0] pix_cr,
  output logic              fld_f,
  output logic              vblank,
  output logic              hflag,
  output logic              sav_pulse,
  output logic              eav_pulse,
  output logic              field_start,
  output logic              code_err
);
  logic              acc, is_status, stat_ok, is_sample;
  logic              stat_good, stat_bad, start_line, stop_line, emit;
  xy_t               xy;
  logic [7:0]        code8;
  logic [WORD_W-1:0] e_y, e_cb, e_cr;

  assign in_ready   = !pix_valid || pix_ready;
  assign acc        = in_valid && in_ready;
  assign stat_good  = acc && stat_ok;
  assign stat_bad   = acc && is_status && !stat_ok;
  assign start_line = stat_good && !xy.h && !xy.v;
  assign stop_line  = stat_good && (xy.h || xy.v);

  trs_detect #(.WORD_W(WORD_W)) u_det (
    .clk(clk), .rst(rst), .acc(acc), .word(in_data),
    .is_status(is_status), .stat_ok(stat_ok), .is_sample(is_sample),
    .xy(xy), .code8(code8)
  );

  chroma_demux #(.WORD_W(WORD_W)) u_dmx (
    .clk(clk), .rst(rst), .take(acc && is_sample),
    .start_line(start_line), .stop_line(stop_line), .word(in_data),
    .emit(emit), .emit_y(e_y), .emit_cb(e_cb), .emit_cr(e_cr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid   <= 1'b0;
      pix_y       <= '0;
      pix_cb      <= '0;
      pix_cr      <= '0;
      fld_f       <= 1'b0;
      vblank      <= 1'b0;
      hflag       <= 1'b0;
      sav_pulse   <= 1'b0;
      eav_pulse   <= 1'b0;
      field_start <= 1'b0;
      code_err    <= 1'b0;
    end else begin
      sav_pulse   <= stat_good && !xy.h;
      eav_pulse   <= stat_good && xy.h;
      field_start <= stat_good && ((code8 == 8'h80) || (code8 == 8'hC7));
      code_err    <= stat_bad;
      if (stat_good) begin
        fld_f  <= xy.f;
        vblank <= xy.v;
        hflag  <= xy.h;
      end
      if (emit) begin
        pix_valid <= 1'b1;
        pix_y     <= e_y;
        pix_cb    <= e_cb;
        pix_cr    <= e_cr;
      end else if (pix_ready) begin
        pix_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/video_trs_decoder_chk.sv
module video_trs_decoder_chk #(
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              pix_valid,
  input logic              pix_ready,
  input logic [WORD_W-1:0] pix_y,
  input logic [WORD_W-1:0] pix_cb,
  input logic [WORD_W-1:0] pix_cr,
  input logic              fld_f,
  input logic              vblank,
  input logic              hflag,
  input logic              sav_pulse,
  input logic              eav_pulse,
  input logic              field_start,
  input logic              code_err
);
  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> !pix_valid && !sav_pulse && !eav_pulse && !code_err && !fld_f && !vblank);

  p_err_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    code_err |-> !sav_pulse && !eav_pulse && $stable(fld_f) && $stable(vblank) && $stable(hflag));

  p_pulse_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(sav_pulse && eav_pulse));

  p_field_start_r5: assert property (@(posedge clk) disable iff (rst)
    field_start |-> sav_pulse && !vblank);

  p_vblank_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    vblank && !pix_valid |=> !pix_valid);

  p_eav_stop_r8: assert property (@(posedge clk) disable iff (rst)
    eav_pulse |=> !$rose(pix_valid));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    pix_valid && !pix_ready |=> pix_valid && $stable(pix_y) && $stable(pix_cb) && $stable(pix_cr));

  p_stall_r9: assert property (@(posedge clk) disable iff (rst)
    pix_valid && !pix_ready |-> !in_ready);
endmodule

bind video_trs_decoder video_trs_decoder_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .pix_valid(pix_valid),
  .pix_ready(pix_ready), .pix_y(pix_y), .pix_cb(pix_cb), .pix_cr(pix_cr),
  .fld_f(fld_f), .vblank(vblank), .hflag(hflag), .sav_pulse(sav_pulse),
  .eav_pulse(eav_pulse), .field_start(field_start), .code_err(code_err)
);

// File: tb/video_trs_decoder_tb_top.sv
module video_trs_decoder_tb_top;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_data = '0;
  logic         pix_valid;
  logic         pix_ready = 1'b1;
  logic [W-1:0] pix_y, pix_cb, pix_cr;
  logic         fld_f, vblank, hflag, sav_pulse, eav_pulse, field_start, code_err;

  int n_chk = 0, n_err = 0;
  int exp_n = 0, got_n = 0;
  bit rnd_ready = 1'b0;
  bit finished = 1'b0;
  logic [W-1:0] exp_y [0:4095];
  logic [W-1:0] exp_cb[0:4095];
  logic [W-1:0] exp_cr[0:4095];

  always #10 clk = ~clk;

  video_trs_decoder #(.WORD_W(W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_y(pix_y), .pix_cb(pix_cb), .pix_cr(pix_cr), .fld_f(fld_f),
    .vblank(vblank), .hflag(hflag), .sav_pulse(sav_pulse),
    .eav_pulse(eav_pulse), .field_start(field_start), .code_err(code_err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] xy_word(input bit f, input bit v, input bit h);
    logic [7:0] b;
    b = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    return {b, 2'b00};
  endfunction

  function automatic logic [W-1:0] rnd_luma();
    return W'(64 + ($urandom % 880));
  endfunction

  function automatic logic [W-1:0] rnd_chroma();
    return W'(64 + ($urandom % 900));
  endfunction

  always @(posedge clk) begin
    #1;
    pix_ready = rnd_ready ? (($urandom % 4) != 0) : 1'b1;
  end

  logic         hold_pend = 1'b0;
  logic [W-1:0] hy, hcb, hcr;
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_pend) begin
        chk(pix_valid && pix_y == hy && pix_cb == hcb && pix_cr == hcr,
            "R9 hold", {pix_y, pix_cr}, {hy, hcr});
      end
      hold_pend = pix_valid && !pix_ready;
      if (hold_pend) begin
        chk(!in_ready, "R9 stall", in_ready, 0);
        hy = pix_y; hcb = pix_cb; hcr = pix_cr;
      end
      if (pix_valid && pix_ready) begin
        if (got_n < exp_n)
          chk(pix_y == exp_y[got_n] && pix_cb == exp_cb[got_n] && pix_cr == exp_cr[got_n],
              "R6 pixel", {pix_y, pix_cb, pix_cr}, {exp_y[got_n], exp_cb[got_n], exp_cr[got_n]});
        else
          chk(1'b0, "R7/R8 unexpected pixel", pix_y, 0);
        got_n++;
      end
    end
  end

  task automatic send(input logic [W-1:0] w);
    in_data  = w;
    in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic send_code(input logic [W-1:0] w);
    send('1); send('0); send('0); send(w);
  endtask

  task automatic push_exp(input logic [W-1:0] y, input logic [W-1:0] cb, input logic [W-1:0] cr);
    exp_y[exp_n] = y; exp_cb[exp_n] = cb; exp_cr[exp_n] = cr;
    exp_n++;
  endtask

  task automatic rnd_line(input bit f, input bit v, input int pairs);
    logic [W-1:0] cb, y0, cr, y1;
    send_code(xy_word(f, v, 1'b0));
    for (int i = 0; i < pairs; i++) begin
      cb = rnd_chroma(); y0 = rnd_luma(); cr = rnd_chroma(); y1 = rnd_luma();
      if (!v) begin
        push_exp(y0, cb, cr);
        push_exp(y1, cb, cr);
      end
      send(cb); send(y0); send(cr); send(y1);
    end
    send_code(xy_word(f, v, 1'b1));
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int snap;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: everything low while in reset
    chk(!pix_valid && !fld_f && !vblank && !hflag && !sav_pulse && !eav_pulse &&
        !field_start && !code_err && pix_y == 0, "R1 reset", {pix_valid, fld_f, vblank}, 0);
    @(posedge clk); #1; rst = 1'b0;

    // R2, R4, R5: field-1 active start code 10'h200
    send_code(10'h200);
    chk(sav_pulse && !eav_pulse, "R4 sav pulse", {sav_pulse, eav_pulse}, 2'b10);
    chk(field_start, "R5 field start 200", field_start, 1);
    chk({fld_f, vblank, hflag} == 3'b000, "R2 flags after 200", {fld_f, vblank, hflag}, 0);

    // R6, R10: one Cb Y Cr Y group
    push_exp(10'h111, 10'h155, 10'h166);
    push_exp(10'h122, 10'h155, 10'h166);
    send(10'h155); send(10'h111);
    chk(!pix_valid, "R6 no pixel before Cr", pix_valid, 0);
    send(10'h166);
    chk(pix_valid && pix_y == 10'h111 && pix_cb == 10'h155 && pix_cr == 10'h166,
        "R10 pixel after Cr", pix_y, 10'h111);
    send(10'h122);
    chk(pix_valid && pix_y == 10'h122 && pix_cr == 10'h166, "R10 pixel after Y1", pix_y, 10'h122);

    // R4: end of line
    send_code(xy_word(1'b0, 1'b0, 1'b1));
    chk(eav_pulse && !sav_pulse && !field_start, "R4 eav pulse", {eav_pulse, field_start}, 2'b10);
    chk(hflag, "R2 hflag after eav", hflag, 1);

    // R8: samples after end of line yield nothing
    snap = got_n;
    send(10'h180); send(10'h190); send(10'h1A0); send(10'h1B0);
    repeat (3) @(posedge clk);
    #1;
    chk(got_n == snap && !pix_valid, "R8 no pixel after eav", got_n, snap);

    // R5, R2: field-2 start code 10'h31C
    send_code(10'h31C);
    chk(field_start && sav_pulse, "R5 field start 31C", field_start, 1);
    chk({fld_f, vblank, hflag} == 3'b100, "R2 flags after 31C", {fld_f, vblank, hflag}, 3'b100);
    send_code(xy_word(1'b1, 1'b0, 1'b1));

    // R7: blanking line start gives no pixels, no field start
    snap = got_n;
    send_code(xy_word(1'b0, 1'b1, 1'b0));
    chk(sav_pulse && !field_start && vblank, "R7 blank sav", {sav_pulse, field_start, vblank}, 3'b101);
    send(10'h140); send(10'h150); send(10'h160); send(10'h170);
    repeat (3) @(posedge clk);
    #1;
    chk(got_n == snap, "R7 no pixel in blanking", got_n, snap);

    // R3: flipped check bit
    send_code(xy_word(1'b1, 1'b0, 1'b0) ^ 10'h020);
    chk(code_err && !sav_pulse && !eav_pulse, "R3 error pulse", {code_err, sav_pulse}, 2'b10);
    chk({fld_f, vblank, hflag} == 3'b010, "R3 flags kept", {fld_f, vblank, hflag}, 3'b010);
    // R3: leading bit zero
    send_code(xy_word(1'b0, 1'b0, 1'b0) & 10'h1FF);
    chk(code_err && !sav_pulse, "R3 msb zero", code_err, 1);

    // Random lines under back-pressure
    rnd_ready = 1'b1;
    for (int l = 0; l < 40; l++)
      rnd_line(1'($urandom % 2), (($urandom % 5) == 0), 1 + ($urandom % 12));
    rnd_ready = 1'b0;
    repeat (10) @(posedge clk);
    #1;
    chk(got_n == exp_n, "R6 pixel count", got_n, exp_n);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule